// File: doc/BRIEF.md
# Update Rectangle Clipper

This unit takes a request to refresh part of a 176 by 220 pixel screen and turns it into a copy descriptor for a pixel copy engine. The request gives a signed corner (x, y) and a signed size (width, height). The unit clips the rectangle to the visible area, one axis at a time. It then either drops the request, or emits one descriptor. The descriptor gives a linear start offset into the frame buffer, a column count, a row count and a flag that selects between two copy shapes.

A region that spans every column is emitted as a single contiguous run of width times height pixels with one row. The copy engine can then move it in one burst. Any narrower region is emitted as a rectangle that the engine copies row by row. A display-enable input gates the request side. While the display is dark, requests are accepted and discarded.

The unit has a two-stage pipeline. The first stage clips and rejects. The second stage forms the start offset and picks the copy shape. Both ends use a valid/ready handshake, and one stall enable freezes the whole pipeline.

Top module: `rect_clip_unit`

## Requirements
- R1: A request accepted while `disp_on` is low produces no descriptor.
- R2: When x + width exceeds 176, the width becomes 176 - x. This is done before the left clip.
- R3: When x is negative, after the right clip, x is added to the width and x becomes 0.
- R4: A request whose width after clipping is zero or negative produces no descriptor.
- R5: The y and height fields are clipped against 220 by the same bottom-then-top rule. A height of zero or less after clipping drops the request.
- R6: When the clipped width is 176, the descriptor has `out_run` = 1, `out_cols` = 176 × height, `out_rows` = 1 and `out_addr` = y × 176.
- R7: Otherwise the descriptor has `out_run` = 0, `out_cols` = clipped width, `out_rows` = clipped height and `out_addr` = y × 176 + x, using the clipped x and y.
- R8: While `out_valid` is high and `out_ready` is low, the descriptor is held unchanged and `in_ready` is low. `in_ready` is high whenever `out_valid` is low.
- R9: With no stall, a descriptor appears on the second rising edge after the request is accepted. It is not present after the first.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_on | input | 1 | Display enabled; when low, requests are discarded |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge |
| in_x | input | 11 | Signed left column |
| in_y | input | 11 | Signed top row |
| in_w | input | 11 | Signed width |
| in_h | input | 11 | Signed height |
| out_valid | output | 1 | Descriptor present |
| out_ready | input | 1 | Consumer takes descriptor |
| out_run | output | 1 | 1 = single linear run, 0 = row-by-row rectangle |
| out_addr | output | 16 | Linear pixel offset of first pixel |
| out_cols | output | 16 | Pixels per row (run length when out_run = 1) |
| out_rows | output | 8 | Number of rows |

## Verification
On every cycle, the assertions check the handshake rules: a stalled descriptor holds steady, and the input side is open when the output is empty. They also check that every emitted descriptor is well formed. A run always has one row. A rectangle always has a nonzero size narrower than the screen and stays inside the screen. The idle state after reset is checked too. Only the bench's scenarios can show the exact clipped values for each sign and overflow combination of corner and size, the drop of empty and dark requests, and the two-edge latency. These depend on what went in, which no per-cycle property can see.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  typedef enum logic {
    SHAPE_LINES = 1'b0,
    SHAPE_RUN   = 1'b1
  } copy_shape_e;
endpackage

// File: rtl/rcu_axis_clip.sv
// One-axis clipper: far edge first, then near edge, then emptiness test.
module rcu_axis_clip #(
  parameter int IN_W  = 11,
  parameter int LIMIT = 176,
  parameter int AXW   = 8
) (
  input  logic signed [IN_W-1:0] pos_i,
  input  logic signed [IN_W-1:0] len_i,
  output logic [AXW-1:0]         pos_o,
  output logic [AXW-1:0]         len_o,
  output logic                   keep_o
);
  localparam int SW = IN_W + 1;
  localparam logic signed [SW-1:0] LIM = SW'(LIMIT);

  logic signed [SW-1:0] p;
  logic signed [SW-1:0] l;

  always_comb begin
    p = {pos_i[IN_W-1], pos_i};
    l = {len_i[IN_W-1], len_i};
    if (p + l > LIM) begin
      l = LIM - p;
    end
    if (p < 0) begin
      l = l + p;
      p = '0;
    end
    keep_o = (l > 0);
    pos_o  = p[AXW-1:0];
    len_o  = l[AXW-1:0];
  end
endmodule

// File: rtl/rcu_clip_stage.sv
// Stage 1: clip both axes, gate on display state, register survivors.
module rcu_clip_stage #(
  parameter int IN_W   = 11,
  parameter int DISP_W = 176,
  parameter int DISP_H = 220,
  parameter int AXW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   disp_on,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_x,
  input  logic signed [IN_W-1:0] in_y,
  input  logic signed [IN_W-1:0] in_w,
  input  logic signed [IN_W-1:0] in_h,
  output logic                   s1_valid,
  output logic [AXW-1:0]         s1_x,
  output logic [AXW-1:0]         s1_y,
  output logic [AXW-1:0]         s1_w,
  output logic [AXW-1:0]         s1_h
);
  localparam int NAX = 2;

  logic signed [IN_W-1:0] ax_pos [NAX];
  logic signed [IN_W-1:0] ax_len [NAX];
  logic [AXW-1:0]         c_pos  [NAX];
  logic [AXW-1:0]         c_len  [NAX];
  logic [NAX-1:0]         c_keep;

  assign ax_pos[0] = in_x;
  assign ax_len[0] = in_w;
  assign ax_pos[1] = in_y;
  assign ax_len[1] = in_h;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    localparam int LIM = (a == 0) ? DISP_W : DISP_H;
    rcu_axis_clip #(
      .IN_W (IN_W),
      .LIMIT(LIM),
      .AXW  (AXW)
    ) u_clip (
      .pos_i (ax_pos[a]),
      .len_i (ax_len[a]),
      .pos_o (c_pos[a]),
      .len_o (c_len[a]),
      .keep_o(c_keep[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_x     <= '0;
      s1_y     <= '0;
      s1_w     <= '0;
      s1_h     <= '0;
    end else if (en) begin
      s1_valid <= in_valid && disp_on && (&c_keep);
      s1_x     <= c_pos[0];
      s1_y     <= c_pos[1];
      s1_w     <= c_len[0];
      s1_h     <= c_len[1];
    end
  end
endmodule

// File: rtl/rcu_emit_stage.sv
// Stage 2: linear offset and copy shape, registered onto the output.
module rcu_emit_stage
  import rcu_pkg::*;
#(
  parameter int DISP_W = 176,
  parameter int AXW    = 8,
  parameter int AW     = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           s1_valid,
  input  logic [AXW-1:0] s1_x,
  input  logic [AXW-1:0] s1_y,
  input  logic [AXW-1:0] s1_w,
  input  logic [AXW-1:0] s1_h,
  output logic           out_valid,
  output copy_shape_e    out_shape,
  output logic [AW-1:0]  out_addr,
  output logic [AW-1:0]  out_cols,
  output logic [AXW-1:0] out_rows
);
  localparam logic [AW-1:0]  W_A   = AW'(DISP_W);
  localparam logic [AXW-1:0] W_AX  = AXW'(DISP_W);
  localparam logic [AXW-1:0] ONE_R = AXW'(1);

  logic          full_row;
  logic [AW-1:0] row_base;
  logic [AW-1:0] run_len;

  always_comb begin
    full_row = (s1_w == W_AX);
    row_base = AW'(s1_y) * W_A;
    run_len  = AW'(s1_h) * W_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_shape <= SHAPE_LINES;
      out_addr  <= '0;
      out_cols  <= '0;
      out_rows  <= '0;
    end else if (en) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_addr <= row_base + AW'(s1_x);
        if (full_row) begin
          out_shape <= SHAPE_RUN;
          out_cols  <= run_len;
          out_rows  <= ONE_R;
        end else begin
          out_shape <= SHAPE_LINES;
          out_cols  <= AW'(s1_w);
          out_rows  <= s1_h;
        end
      end
    end
  end
endmodule

// File: rtl/rect_clip_unit.sv
module rect_clip_unit
  import rcu_pkg::*;
#(
  parameter int IN_W   = 11,
  parameter int DISP_W = 176,
  parameter int DISP_H = 220,
  localparam int MAXD  = (DISP_W > DISP_H) ? DISP_W : DISP_H,
  localparam int AXW   = $clog2(MAXD + 1),
  localparam int AW    = $clog2(DISP_W * DISP_H + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   disp_on,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_x,
  input  logic signed [IN_W-1:0] in_y,
  input  logic signed [IN_W-1:0] in_w,
  input  logic signed [IN_W-1:0] in_h,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_run,
  output logic [AW-1:0]          out_addr,
  output logic [AW-1:0]          out_cols,
  output logic [AXW-1:0]         out_rows
);
  logic           en;
  logic           s1_valid;
  logic [AXW-1:0] s1_x;
  logic [AXW-1:0] s1_y;
  logic [AXW-1:0] s1_w;
  logic [AXW-1:0] s1_h;
  copy_shape_e    shape;

  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign out_run  = (shape == SHAPE_RUN);

  rcu_clip_stage #(
    .IN_W  (IN_W),
    .DISP_W(DISP_W),
    .DISP_H(DISP_H),
    .AXW   (AXW)
  ) u_clip (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .disp_on (disp_on),
    .in_valid(in_valid),
    .in_x    (in_x),
    .in_y    (in_y),
    .in_w    (in_w),
    .in_h    (in_h),
    .s1_valid(s1_valid),
    .s1_x    (s1_x),
    .s1_y    (s1_y),
    .s1_w    (s1_w),
    .s1_h    (s1_h)
  );

  rcu_emit_stage #(
    .DISP_W(DISP_W),
    .AXW   (AXW),
    .AW    (AW)
  ) u_emit (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .s1_valid (s1_valid),
    .s1_x     (s1_x),
    .s1_y     (s1_y),
    .s1_w     (s1_w),
    .s1_h     (s1_h),
    .out_valid(out_valid),
    .out_shape(shape),
    .out_addr (out_addr),
    .out_cols (out_cols),
    .out_rows (out_rows)
  );
endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
  parameter int DISP_W = 176,
  parameter int DISP_H = 220,
  parameter int AXW    = 8,
  parameter int AW     = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic           out_run,
  input logic [AW-1:0]  out_addr,
  input logic [AW-1:0]  out_cols,
  input logic [AXW-1:0] out_rows
);
  localparam int AREA = DISP_W * DISP_H;

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_cols)
      && $stable(out_rows) && $stable(out_run)); // R8

  AST_BLOCK_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R8

  AST_OPEN_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R8

  AST_RUN_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_run |-> out_rows == AXW'(1) && out_cols > 0
      && (int'(out_addr) % DISP_W) == 0); // R6

  AST_LINES_NARROW: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_run |-> out_cols > 0 && int'(out_cols) < DISP_W
      && out_rows > 0 && int'(out_rows) <= DISP_H); // R7

  AST_INSIDE_ROW: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_run |-> (int'(out_addr) % DISP_W) + int'(out_cols) <= DISP_W); // R2

  AST_INSIDE_SCREEN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> int'(out_addr) < AREA); // R5

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R10
endmodule

bind rect_clip_unit rcu_checker #(
  .DISP_W(DISP_W),
  .DISP_H(DISP_H),
  .AXW   (AXW),
  .AW    (AW)
) u_rcu_checker (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_run  (out_run),
  .out_addr (out_addr),
  .out_cols (out_cols),
  .out_rows (out_rows)
);

// File: tb/rect_clip_unit_bench.sv
`timescale 1ns/1ps
module rect_clip_unit_bench;
  localparam int SW = 176;
  localparam int SH = 220;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               disp_on = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [10:0] in_x = '0;
  logic signed [10:0] in_y = '0;
  logic signed [10:0] in_w = '0;
  logic signed [10:0] in_h = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic               out_run;
  logic [15:0]        out_addr;
  logic [15:0]        out_cols;
  logic [7:0]         out_rows;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  rect_clip_unit u_rect_clip_unit (
    .clk(clk), .rst(rst), .disp_on(disp_on),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_w(in_w), .in_h(in_h),
    .out_valid(out_valid), .out_ready(out_ready), .out_run(out_run),
    .out_addr(out_addr), .out_cols(out_cols), .out_rows(out_rows)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference clip of one axis, straight from the requirements.
  function automatic void ref_axis(input int p, input int l, input int lim,
                                   output int po, output int lo,
                                   output bit far_cut, output bit near_cut);
    far_cut  = 1'b0;
    near_cut = 1'b0;
    if (p + l > lim) begin l = lim - p; far_cut = 1'b1; end
    if (p < 0) begin l = l + p; p = 0; near_cut = 1'b1; end
    po = p;
    lo = l;
  endfunction

  task automatic send_and_check(input int x, input int y, input int w, input int h);
    int cx, cy, cw, ch;
    bit fx, nx, fy, ny, keep, run;
    int e_addr, e_cols, e_rows;
    string tag;
    ref_axis(x, w, SW, cx, cw, fx, nx);
    ref_axis(y, h, SH, cy, ch, fy, ny);
    keep   = (cw > 0) && (ch > 0);
    run    = (cw == SW);
    e_addr = cy * SW + cx;
    e_cols = run ? SW * ch : cw;
    e_rows = run ? 1 : ch;
    if (cw <= 0)      tag = "R4";
    else if (ch <= 0) tag = "R5";
    else if (run)     tag = "R6";
    else if (nx)      tag = "R3";
    else if (fx)      tag = "R2";
    else if (fy || ny) tag = "R5";
    else              tag = "R7";

    @(negedge clk);
    in_x = 11'(x); in_y = 11'(y); in_w = 11'(w); in_h = 11'(h);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(!out_valid, "R9", "out_valid one edge after accept", int'(out_valid), 0);
    @(negedge clk);
    if (!keep) begin
      check(!out_valid, tag, "dropped request emitted", int'(out_valid), 0);
    end else begin
      check(out_valid, tag, "out_valid", int'(out_valid), 1);
      check(out_run == run && out_addr == 16'(e_addr) && out_cols == 16'(e_cols)
            && out_rows == 8'(e_rows), tag, "addr/cols/rows/run",
            int'(out_addr) * 1000 + int'(out_cols), e_addr * 1000 + e_cols);
      check(out_run == run && out_rows == 8'(e_rows), tag, "rows/run",
            int'(out_rows) * 2 + int'(out_run), e_rows * 2 + int'(run));
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int xs[10] = '{-1024, -177, -5, -1, 0, 1, 100, 175, 176, 1023};
    int ws[9]  = '{-1024, -1, 0, 1, 5, 175, 176, 177, 1023};
    int ys[8]  = '{-1024, -221, -3, 0, 1, 219, 220, 1023};
    int hs[8]  = '{-1, 0, 1, 2, 219, 220, 221, 1023};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle after reset
    check(!out_valid, "R10", "out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R10", "in_ready after reset", int'(in_ready), 1);

    // R1: dark display discards a perfectly visible request
    disp_on = 1'b0;
    in_x = 11'sd10; in_y = 11'sd10; in_w = 11'sd20; in_h = 11'sd20;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid, "R1", "output while dark", int'(out_valid), 0);
    @(negedge clk);
    check(!out_valid, "R1", "output while dark, later", int'(out_valid), 0);
    disp_on = 1'b1;

    // R2..R7, R9: sweep of corner/size combinations
    foreach (xs[i]) foreach (ws[j]) foreach (ys[k]) foreach (hs[m])
      send_and_check(xs[i], ys[k], ws[j], hs[m]);

    // R8: stall holds output and blocks input; order kept across release
    @(negedge clk);
    out_ready = 1'b0;
    in_x = 11'sd10; in_y = 11'sd20; in_w = 11'sd5; in_h = 11'sd3;
    in_valid = 1'b1;
    @(negedge clk);
    in_x = 11'sd0; in_y = 11'sd1; in_w = 11'sd176; in_h = 11'sd2;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_addr == 16'd3530 && out_cols == 16'd5, "R8",
          "first descriptor under stall", int'(out_addr), 3530);
    check(!in_ready, "R8", "in_ready during stall", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    check(out_valid && out_addr == 16'd3530 && out_rows == 8'd3 && !out_run, "R8",
          "descriptor held", int'(out_addr), 3530);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid && out_run && out_addr == 16'd176 && out_cols == 16'd352
          && out_rows == 8'd1, "R8", "second descriptor after release",
          int'(out_cols), 352);
    @(negedge clk);
    check(!out_valid && in_ready, "R8", "drained", int'(out_valid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule